// File: doc/BRIEF.md
# Modulo-7 Acceptance Tree

This block decides in a single clock whether an unsigned input word is a multiple of seven. It does not step a remainder automaton one bit per clock. Each input bit is turned into a complete next-remainder table, the table the automaton would apply on reading that bit. Neighbouring tables are then merged pairwise in a balanced tree, so the logic depth grows with the logarithm of the word width. The root table sends the start remainder to the final remainder. The output flag is raised when that final remainder lies in the accepting set.

The automaton reads the most significant bit first. On each bit it moves from remainder r to (2r + b) mod 7. It starts at remainder 0 and accepts only remainder 0. The word width and the modulus are parameters. An optional input register (`IN_REG`) adds one pipeline stage in front of the tree, and the flag itself is always registered. A new word can therefore be presented on every clock.

Top module: `rem_accept_tree`

## Requirements
- R1: While `rst` is high at a rising edge, `accept` reads 0 after that edge, even if `din` is zero.
- R2: `accept` becomes valid 1 + `IN_REG` rising edges after `din` is sampled. It is 1 exactly when `din`, read as an unsigned number with bit `DATA_W-1` most significant, leaves remainder 0 when divided by 7.
- R3: An all-zero input word is accepted.
- R4: An all-ones input word is accepted exactly when `DATA_W` is a multiple of 3 (all-ones is 4095 at 12 bits, accepted, and 4294967295 at 32 bits, rejected).
- R5: A word with exactly one bit set is never accepted, for every bit position.
- R6: Every multiple of 7 is accepted, including the largest one that fits in `DATA_W` bits. The values one above and one below a multiple are rejected.
- R7: The result is correct when a tree level holds an odd number of tables and the last table is passed up unpaired. At `DATA_W` = 12 the levels hold 12, 6, 3, 2 and 1 tables, and every input value gives the correct result.
- R8: A different word may be presented on every clock. Each result depends only on the word it belongs to and not on the words next to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Word under test, unsigned, MSB read first |
| accept | output | 1 | Registered flag: word is a multiple of 7 |

## Verification
The corner cases are the extremes of the word and the shape of the tree. A table merge done in the wrong order (right then left) gives wrong results on the single-bit words and the ±1 neighbours. The same holds for a leaf that reads the bits least significant first. A bad pass-through of an unpaired table, at the 3-table level of the 12-bit instance, shows up during the exhaustive 12-bit sweep. All-ones and the largest fitting multiple expose an off-by-one in the leaf table or the final lookup. The back-to-back sweep catches a pipeline that is one stage short or one stage long, because neighbouring words would then be reported in the wrong slot.

// File: rtl/rem_accept_pkg.sv
package rem_accept_pkg;
  // Width of one remainder index for a given modulus.
  function automatic int st_width(input int m);
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  // Number of tables left at tree level lvl for n leaves.
  function automatic int level_count(input int n, input int lvl);
    return (n + (1 << lvl) - 1) >> lvl;
  endfunction

  // Number of tree levels, leaves included.
  function automatic int level_total(input int n);
    return (n <= 1) ? 1 : $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/rem_bit_map.sv
// Next-remainder table for one input bit: entry q holds (2q + b) mod MOD.
module rem_bit_map #(
  parameter int MOD   = 7,
  parameter int ST_W  = 3,
  parameter int MAP_W = MOD * ST_W
) (
  input  logic             b,
  output logic [MAP_W-1:0] map
);
  genvar q;
  for (q = 0; q < MOD; q++) begin : g_ent
    localparam int NXT0 = (2 * q) % MOD;
    localparam int NXT1 = (2 * q + 1) % MOD;
    assign map[q*ST_W +: ST_W] = b ? ST_W'(NXT1) : ST_W'(NXT0);
  end
endmodule

// File: rtl/rem_map_compose.sv
// Merge two adjacent tables: the earlier segment is applied first.
module rem_map_compose #(
  parameter int MOD   = 7,
  parameter int ST_W  = 3,
  parameter int MAP_W = MOD * ST_W
) (
  input  logic [MAP_W-1:0] first,
  input  logic [MAP_W-1:0] second,
  output logic [MAP_W-1:0] joined
);
  logic [ST_W-1:0] mid;

  always_comb begin
    joined = '0;
    mid    = '0;
    for (int q = 0; q < MOD; q++) begin
      mid = first[q*ST_W +: ST_W];
      for (int r = 0; r < MOD; r++) begin
        if (mid == ST_W'(r)) begin
          joined[q*ST_W +: ST_W] = second[r*ST_W +: ST_W];
        end
      end
    end
  end
endmodule

// File: rtl/rem_compose_tree.sv
// Balanced merge tree over N one-bit tables, MSB-first leaf order.
module rem_compose_tree
  import rem_accept_pkg::*;
#(
  parameter int N     = 32,
  parameter int MOD   = 7,
  parameter int ST_W  = 3,
  parameter int MAP_W = MOD * ST_W
) (
  input  logic [N-1:0]     bits,
  output logic [MAP_W-1:0] whole
);
  localparam int LEVELS = level_total(N);

  genvar l, i;
  for (l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = level_count(N, l);
    logic [MAP_W-1:0] maps [CNT];

    if (l == 0) begin : g_leaf
      for (i = 0; i < CNT; i++) begin : g_bit
        rem_bit_map #(.MOD(MOD), .ST_W(ST_W), .MAP_W(MAP_W)) u_bit (
          .b   (bits[N-1-i]),
          .map (maps[i])
        );
      end
    end else begin : g_node
      localparam int PCNT = level_count(N, l - 1);
      for (i = 0; i < CNT; i++) begin : g_pair
        if (2 * i + 1 < PCNT) begin : g_join
          rem_map_compose #(.MOD(MOD), .ST_W(ST_W), .MAP_W(MAP_W)) u_join (
            .first  (g_lvl[l-1].maps[2*i]),
            .second (g_lvl[l-1].maps[2*i+1]),
            .joined (maps[i])
          );
        end else begin : g_pass
          assign maps[i] = g_lvl[l-1].maps[2*i];
        end
      end
    end
  end

  assign whole = g_lvl[LEVELS-1].maps[0];
endmodule

// File: rtl/rem_accept_decode.sv
// Look up the start state in the root table and OR over accepting states.
module rem_accept_decode #(
  parameter int             MOD         = 7,
  parameter int             ST_W        = 3,
  parameter int             MAP_W       = MOD * ST_W,
  parameter int             START       = 0,
  parameter logic [MOD-1:0] ACCEPT_MASK = MOD'(1)
) (
  input  logic [MAP_W-1:0] root,
  output logic             hit
);
  logic [ST_W-1:0] final_st;

  always_comb begin
    final_st = root[START*ST_W +: ST_W];
    hit      = 1'b0;
    for (int s = 0; s < MOD; s++) begin
      if (ACCEPT_MASK[s] && (final_st == ST_W'(s))) begin
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rem_accept_tree.sv
module rem_accept_tree
  import rem_accept_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MOD    = 7,
  parameter int IN_REG = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic              accept
);
  localparam int ST_W  = st_width(MOD);
  localparam int MAP_W = MOD * ST_W;

  logic [DATA_W-1:0] word;
  logic [MAP_W-1:0]  root;
  logic              hit;

  if (IN_REG != 0) begin : g_in_reg
    always_ff @(posedge clk) begin
      if (rst) word <= '0;
      else     word <= din;
    end
  end else begin : g_in_wire
    assign word = din;
  end

  rem_compose_tree #(.N(DATA_W), .MOD(MOD), .ST_W(ST_W), .MAP_W(MAP_W)) u_tree (
    .bits  (word),
    .whole (root)
  );

  rem_accept_decode #(
    .MOD(MOD), .ST_W(ST_W), .MAP_W(MAP_W), .START(0), .ACCEPT_MASK(MOD'(1))
  ) u_dec (
    .root (root),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) accept <= 1'b0;
    else     accept <= hit;
  end
endmodule

// File: rtl/rem_accept_tree_chk.sv
module rem_accept_tree_chk #(
  parameter int DATA_W = 32,
  parameter int MOD    = 7,
  parameter int IN_REG = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic              accept
);
  localparam int LAT = 1 + ((IN_REG != 0) ? 1 : 0);
  localparam logic ONES_OK = ((DATA_W % 3) == 0);

  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                     since_rst <= '0;
    else if (since_rst < 2'(LAT)) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'(LAT));

  a_r2_matches_mod: assert property (@(posedge clk) disable iff (rst)
    warm |-> (accept == (($past(din, LAT) % DATA_W'(MOD)) == '0)));

  a_r3_zero_accepted: assert property (@(posedge clk) disable iff (rst)
    (warm && ($past(din, LAT) == '0)) |-> accept);

  a_r4_all_ones: assert property (@(posedge clk) disable iff (rst)
    (warm && ($past(din, LAT) == '1)) |-> (accept == ONES_OK));

  a_r5_single_bit_rejected: assert property (@(posedge clk) disable iff (rst)
    (warm && ($countones($past(din, LAT)) == 1)) |-> !accept);
endmodule

bind rem_accept_tree rem_accept_tree_chk #(
  .DATA_W(DATA_W), .MOD(MOD), .IN_REG(IN_REG)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .accept(accept)
);

// File: tb/rem_accept_tree_bench.sv
module rem_accept_tree_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din_a = '0;
  logic [11:0] din_b = '0;
  logic        acc_a, acc_b;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  rem_accept_tree #(.DATA_W(32), .MOD(7), .IN_REG(0)) u_rem_accept_tree (
    .clk(clk), .rst(rst), .din(din_a), .accept(acc_a)
  );

  rem_accept_tree #(.DATA_W(12), .MOD(7), .IN_REG(1)) u_rem_accept_tree_w12 (
    .clk(clk), .rst(rst), .din(din_b), .accept(acc_b)
  );

  task automatic chk(input logic got, input logic exp, input string req,
                     input logic [31:0] val);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s din=%0d actual=%0b expected=%0b", req, val, got, exp);
    end
  endtask

  // Wide instance: latency one edge.
  task automatic wide_one(input logic [31:0] v, input string req);
    @(negedge clk) din_a = v;
    @(negedge clk) chk(acc_a, ((v % 32'd7) == 0), req, v);
  endtask

  task automatic t_reset();
    rst = 1'b1; din_a = '0; din_b = '0;
    repeat (4) @(negedge clk);
    chk(acc_a, 1'b0, "R1 wide", din_a);
    chk(acc_b, 1'b0, "R1 narrow", 32'(din_b));
    rst = 1'b0;
  endtask

  task automatic t_extremes();
    wide_one(32'd0, "R3");
    wide_one(32'hFFFF_FFFF, "R4");
    for (int k = 0; k < 32; k++) wide_one(32'd1 << k, "R5");
  endtask

  task automatic t_multiples();
    logic [31:0] top_m;
    top_m = 32'hFFFF_FFFF - (32'hFFFF_FFFF % 32'd7);
    wide_one(top_m, "R6 largest");
    wide_one(top_m - 32'd1, "R6 largest-1");
    wide_one(top_m + 32'd1, "R6 largest+1");
    for (int j = 0; j < 40; j++) begin
      logic [31:0] m;
      m = 32'd7 * ($urandom % 32'd613566756);
      wide_one(m, "R6 multiple");
      wide_one(m + 32'd1, "R6 plus1");
      if (m != 0) wide_one(m - 32'd1, "R6 minus1");
    end
  endtask

  task automatic t_random();
    for (int j = 0; j < 300; j++) wide_one($urandom, "R2");
  endtask

  // Narrow instance: every value back to back, latency two edges.
  task automatic t_narrow_sweep();
    logic [11:0] hist [2];
    for (int i = 0; i <= 4097; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (hist[1] == 12'hFFF)
          chk(acc_b, 1'b1, "R4 narrow", 32'(hist[1]));
        else
          chk(acc_b, ((hist[1] % 12'd7) == 0), "R7 R8", 32'(hist[1]));
      end
      hist[1] = hist[0];
      if (i < 4096) begin
        din_b   = 12'(i);
        hist[0] = 12'(i);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_extremes();
    t_multiples();
    t_random();
    t_narrow_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule